// File: doc/BRIEF.md
# Multicast Tile Copy Distributor

This block serves one bulk-copy request at a time. It fetches a source tile from a global memory port exactly once and broadcasts each fetched 16-byte beat to the scratchpad of every cluster rank selected by a destination bitmask. Every selected rank receives the tile at the same scratchpad offset. Each time a rank accepts a beat, the block issues a byte credit to that rank's transaction-counting barrier. The credit carries the barrier address and the number of valid bytes in the beat.

A requester presents source address, byte length, scratchpad offset, barrier address and rank mask with a valid/ready handshake. The block returns a one-cycle done pulse only after the last credit of the last rank has gone out. Lengths need not be a multiple of 16. The final beat is written with a byte strobe and credited with only its valid bytes, so the credits to each selected rank add up to the request length.

Top module: `mcast_tile_copy`

## Requirements
- R1: `req_ready` is high exactly while the block is idle; a request is taken on a cycle with `req_valid` and `req_ready` both high, and no read or write is presented while `req_ready` is high.
- R2: A request of L bytes with a non-empty effective mask causes exactly ceil(L/16) read grants, at addresses src, src+16, src+32, ... in order, whatever the number of selected ranks.
- R3: Rank r (r below N_RANK) receives every beat exactly once when mask bit r is 1, and nothing when it is 0. Beat k goes to scratchpad address dst+16k with the data read from src+16k.
- R4: Mask bits at positions N_RANK..15 are ignored; a mask whose only set bits lie there behaves as an all-zero mask.
- R5: The next read is not issued until every selected rank has accepted the current beat; while any selected rank stalls, `wr_addr` and `wr_data` hold steady.
- R6: On the cycle rank r accepts a beat, `cr_valid[r]` is high with `cr_bar` equal to the request's barrier address and `cr_bytes` equal to the beat's valid byte count: 16, or L-16k for the final beat. `cr_valid[r]` is never high without an acceptance.
- R7: `wr_strb` bit i is 1 exactly when byte i of the beat is valid, so its population count equals `cr_bytes`.
- R8: A request with zero length or an empty effective mask performs no read, no write and no credit; `req_done` pulses on the cycle after acceptance.
- R9: `req_done` is a one-cycle pulse on the cycle after the final credit of the request, with no read or write presented during it.
- R10: `rd_req` stays high with a stable `rd_addr` until `rd_gnt` is seen; read data is taken on `rd_rvalid` in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_src | input | AW | Global source byte address |
| req_len | input | LENW | Tile length in bytes |
| req_dst | input | OW | Scratchpad byte offset used in every rank |
| req_bar | input | BARW | Barrier address credited in every rank |
| req_mask | input | 16 | Destination rank bitmask |
| req_done | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Global read request |
| rd_addr | output | AW | Global read byte address |
| rd_gnt | input | 1 | Read request granted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | BEAT*8 | Read data beat |
| wr_valid | output | N_RANK | Per-rank scratchpad write valid |
| wr_ready | input | N_RANK | Per-rank scratchpad write ready |
| wr_addr | output | OW | Scratchpad write byte address |
| wr_data | output | BEAT*8 | Scratchpad write data |
| wr_strb | output | BEAT | Byte strobe of the write |
| cr_valid | output | N_RANK | Per-rank barrier credit strobe |
| cr_bar | output | BARW | Barrier address of the credit |
| cr_bytes | output | LENW | Byte count of the credit |

## Verification
The assertions check the cycle-level rules on every cycle: the read request and broadcast beat hold while stalled, the strobe matches the credit size, a credit never exceeds one beat, and the done pulse lasts one cycle with the ports quiet around idle and completion. Only the bench scenarios can show the per-request accounting. These are the single fetch per beat, the exact set of ranks reached, address and data per beat, credits that sum to the request length, and done arriving right after the last credit. The bench covers these under random per-rank backpressure, partial final beats and masks with out-of-range bits.

// File: rtl/mcast_tile_copy.sv
module mcast_tile_copy #(
  parameter int N_RANK = 4,
  parameter int AW     = 32,
  parameter int OW     = 16,
  parameter int BARW   = 16,
  parameter int LENW   = 16,
  parameter int BEAT   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_src,
  input  logic [LENW-1:0]    req_len,
  input  logic [OW-1:0]      req_dst,
  input  logic [BARW-1:0]    req_bar,
  input  logic [15:0]        req_mask,
  output logic               req_done,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_gnt,
  input  logic               rd_rvalid,
  input  logic [BEAT*8-1:0]  rd_rdata,
  output logic [N_RANK-1:0]  wr_valid,
  input  logic [N_RANK-1:0]  wr_ready,
  output logic [OW-1:0]      wr_addr,
  output logic [BEAT*8-1:0]  wr_data,
  output logic [BEAT-1:0]    wr_strb,
  output logic [N_RANK-1:0]  cr_valid,
  output logic [BARW-1:0]    cr_bar,
  output logic [LENW-1:0]    cr_bytes
);
  localparam int DW = BEAT * 8;
  localparam logic [LENW-1:0] BEAT_L = LENW'(BEAT);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WT, S_PUSH, S_DONE} st_t;
  st_t st;

  logic [N_RANK-1:0] sel, pend;
  logic [AW-1:0]     src;
  logic [OW-1:0]     dst;
  logic [BARW-1:0]   bar;
  logic [LENW-1:0]   rem, off;
  logic [DW-1:0]     beat_q;

  wire [N_RANK-1:0] new_sel = req_mask[N_RANK-1:0];
  wire [N_RANK-1:0] left    = pend & ~wr_ready;
  wire              last    = rem <= BEAT_L;
  wire [LENW-1:0]   nbytes  = last ? rem : BEAT_L;

  assign req_ready = st == S_IDLE;
  assign req_done  = st == S_DONE;
  assign rd_req    = st == S_RD;
  assign rd_addr   = src + AW'(off);
  assign wr_addr   = dst + OW'(off);
  assign wr_data   = beat_q;
  assign wr_valid  = (st == S_PUSH) ? pend : '0;
  assign cr_valid  = (st == S_PUSH) ? (pend & wr_ready) : '0;
  assign cr_bar    = bar;
  assign cr_bytes  = nbytes;

  always_comb
    for (int i = 0; i < BEAT; i++)
      wr_strb[i] = LENW'(i) < nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sel    <= '0;
      pend   <= '0;
      src    <= '0;
      dst    <= '0;
      bar    <= '0;
      rem    <= '0;
      off    <= '0;
      beat_q <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (req_valid) begin
            sel <= new_sel;
            src <= req_src;
            dst <= req_dst;
            bar <= req_bar;
            rem <= req_len;
            off <= '0;
            st  <= (new_sel == '0 || req_len == '0) ? S_DONE : S_RD;
          end
        S_RD:
          if (rd_gnt) st <= S_WT;
        S_WT:
          if (rd_rvalid) begin
            beat_q <= rd_rdata;
            pend   <= sel;
            st     <= S_PUSH;
          end
        S_PUSH: begin
          pend <= left;
          if (left == '0) begin
            if (last) st <= S_DONE;
            else begin
              rem <= rem - BEAT_L;
              off <= off + BEAT_L;
              st  <= S_RD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcast_tile_copy_chk.sv
module mcast_tile_copy_chk #(
  parameter int N_RANK = 4,
  parameter int AW     = 32,
  parameter int OW     = 16,
  parameter int LENW   = 16,
  parameter int BEAT   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               req_done,
  input logic               rd_req,
  input logic [AW-1:0]      rd_addr,
  input logic               rd_gnt,
  input logic [N_RANK-1:0]  wr_valid,
  input logic [N_RANK-1:0]  wr_ready,
  input logic [OW-1:0]      wr_addr,
  input logic [BEAT*8-1:0]  wr_data,
  input logic [BEAT-1:0]    wr_strb,
  input logic [N_RANK-1:0]  cr_valid,
  input logic [LENW-1:0]    cr_bytes
);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wr_valid & ~wr_ready)) |=> $stable(wr_data) && $stable(wr_addr) && !rd_req);

  // R6
  credit_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cr_valid) |-> (cr_bytes != '0) && (cr_bytes <= LENW'(BEAT)));

  // R7
  strb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_valid) |-> (LENW'($countones(wr_strb)) == cr_bytes));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (wr_valid == '0) && !rd_req && !req_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_req && (wr_valid == '0) && (cr_valid == '0));
endmodule

bind mcast_tile_copy mcast_tile_copy_chk #(
  .N_RANK(N_RANK), .AW(AW), .OW(OW), .LENW(LENW), .BEAT(BEAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_done(req_done),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_strb(wr_strb), .cr_valid(cr_valid), .cr_bytes(cr_bytes)
);

// File: tb/mcast_tile_copy_tb.sv
module mcast_tile_copy_tb;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_done;
  logic [31:0] req_src = 0;
  logic [15:0] req_len = 0, req_dst = 0, req_bar = 0, req_mask = 0;
  logic rd_req, rd_gnt = 0, rd_rvalid = 0;
  logic [31:0] rd_addr;
  logic [127:0] rd_rdata = 0, wr_data;
  logic [N-1:0] wr_valid, wr_ready = 0, cr_valid;
  logic [15:0] wr_addr, wr_strb, cr_bar, cr_bytes;

  always #5 clk = ~clk;

  mcast_tile_copy #(.N_RANK(N)) u_dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  logic [N-1:0] e_sel;
  logic [31:0] e_src;
  logic [15:0] e_len, e_dst, e_bar;
  int nrd, acc_cyc, last_cr;
  int wcnt[N], csum[N];
  bit done_seen, rd_out;
  int rd_dly;
  logic [31:0] rd_pa;

  function automatic logic [127:0] memdata(input logic [31:0] a);
    return {a ^ 32'hA5A5_0F0F, a * 32'd3 + 32'd1, ~a, a + 32'd77};
  endfunction

  function automatic int beats_of(input logic [15:0] l);
    return (int'(l) + 15) / 16;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
    wr_ready = N'($urandom);
    rd_gnt = 1'($urandom);
    rd_rvalid = 0;
    if (rd_out) begin
      if (rd_dly == 0) begin
        rd_rvalid = 1;
        rd_rdata = memdata(rd_pa);
        rd_out = 0;
      end else rd_dly--;
    end
    #1;
    if (rst_n) begin
      if (req_valid && req_ready) begin
        e_sel = req_mask[N-1:0]; e_src = req_src; e_len = req_len;
        e_dst = req_dst; e_bar = req_bar;
        nrd = 0; acc_cyc = cyc; last_cr = -10;
        for (int r = 0; r < N; r++) begin wcnt[r] = 0; csum[r] = 0; end
      end
      if (rd_req && rd_gnt) begin
        chk(rd_addr == e_src + 32'(16 * nrd), "R2 read address", int'(rd_addr), int'(e_src) + 16 * nrd);
        for (int r = 0; r < N; r++)
          if (e_sel[r]) chk(wcnt[r] == nrd, "R5 read before all ranks accepted", wcnt[r], nrd);
        nrd++;
        rd_out = 1; rd_pa = rd_addr; rd_dly = int'($urandom % 3);
      end
      for (int r = 0; r < N; r++) begin
        if (wr_valid[r] && wr_ready[r]) begin
          int k, eb;
          logic [15:0] es;
          k = wcnt[r];
          eb = int'(e_len) - 16 * k;
          if (eb > 16) eb = 16;
          es = (eb >= 16) ? 16'hFFFF : 16'((32'd1 << eb) - 1);
          chk(e_sel[r], "R3/R4 write to unselected rank", r, -1);
          chk(wr_addr == 16'(int'(e_dst) + 16 * k), "R3 write address", int'(wr_addr), int'(e_dst) + 16 * k);
          chk(wr_data == memdata(e_src + 32'(16 * k)), "R3 write data", int'(wr_data[31:0]), int'(memdata(e_src + 32'(16 * k)) & 128'hFFFF_FFFF));
          chk(cr_valid[r] && cr_bar == e_bar && int'(cr_bytes) == eb, "R6 credit", int'(cr_bytes), eb);
          chk(wr_strb == es, "R7 strobe", int'(wr_strb), int'(es));
          csum[r] += int'(cr_bytes);
          wcnt[r]++;
          last_cr = cyc;
        end else if (cr_valid[r]) chk(0, "R6 credit without acceptance", r, -1);
      end
      if (req_done) begin
        bit zero;
        int b;
        zero = (e_sel == '0) || (e_len == 0);
        b = zero ? 0 : beats_of(e_len);
        if (zero) chk(cyc == acc_cyc + 1, "R8 empty request done timing", cyc - acc_cyc, 1);
        else chk(cyc == last_cr + 1, "R9 done after last credit", cyc - last_cr, 1);
        chk(nrd == b, "R2 read count", nrd, b);
        for (int r = 0; r < N; r++) begin
          chk(wcnt[r] == (e_sel[r] ? b : 0), "R3 beats per rank", wcnt[r], e_sel[r] ? b : 0);
          chk(csum[r] == (e_sel[r] && !zero ? int'(e_len) : 0), "R6 credit total", csum[r], e_sel[r] && !zero ? int'(e_len) : 0);
        end
        done_seen = 1;
      end
    end
  end

  task automatic do_req(input logic [31:0] s, input logic [15:0] l, input logic [15:0] d,
                        input logic [15:0] b, input logic [15:0] m);
    @(negedge clk);
    done_seen = 0;
    req_src = s; req_len = l; req_dst = d; req_bar = b; req_mask = m; req_valid = 1;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    req_valid = 0;
    #2;
    while (!done_seen) begin @(negedge clk); #2; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #2;
    chk(req_ready && !rd_req && wr_valid == 0 && !req_done && cr_valid == 0, "R1 reset state", int'(req_ready), 1);
    rst_n = 1;
    do_req(32'h1000, 16'd0, 16'h40, 16'h11, 16'h000F);   // R8 zero length
    do_req(32'h2000, 16'd48, 16'h80, 16'h12, 16'h0000);  // R8 empty mask
    do_req(32'h3000, 16'd48, 16'h80, 16'h13, 16'hFFF0); // R4 only high bits
    do_req(32'h4000, 16'd1, 16'h00, 16'h14, 16'h0001);
    do_req(32'h5000, 16'd16, 16'h10, 16'h15, 16'h0003);  // ranks 0 and 1
    do_req(32'h6000, 16'd17, 16'h20, 16'h16, 16'hFFFF);  // R4 upper bits with all ranks
    do_req(32'h7000, 16'd100, 16'h30, 16'h17, 16'h000A);
    for (int i = 0; i < 60; i++)
      do_req($urandom, 16'($urandom % 100), 16'($urandom % 1024), 16'($urandom), 16'($urandom));
    finish_run();
  end
endmodule